// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked host read and write an external 8K x 8 asynchronous static RAM. The host raises a one-cycle request with a write flag, address and write data. The controller registers them and runs one complete memory cycle. It then pulses `ready_o` for one clock. On reads, the captured byte is on `rdata_o` during that clock.

On the memory side the controller drives the address bus, two chip selects of opposite polarity, write enable and output enable. It also drives a split tri-state data bus through separate in, out and drive-enable signals. Every memory timing minimum is a parameter in nanoseconds. The controller rounds each one up to whole clock cycles using the clock period parameter.

Between cycles the memory is deselected, with its outputs in high-Z. While a cycle runs, new requests are ignored.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is low and in idle after reset: `sram_sel_n_o`=1, `sram_sel_o`=0, `sram_we_n_o`=1, `sram_oe_n_o`=1, `sram_dq_oe_o`=0, `ready_o`=0. An asynchronous reset in the middle of a cycle returns the strobes to these values at once.
- R2: For an accepted read (`we_i`=0), starting the cycle after acceptance, both selects are active, `sram_we_n_o`=1 and `sram_oe_n_o`=0 for exactly RD_CYC cycles. RD_CYC is the largest of the rounded read cycle, address access and output-enable access times (9 at defaults).
- R3: The read byte is sampled from `sram_dq_i` in the last strobe cycle. It appears on `rdata_o` in the following cycle, together with `ready_o`, and stays there until the next read.
- R4: For an accepted write, both selects are active and `sram_we_n_o`=0 for exactly PULSE_CYC cycles. PULSE_CYC is the largest of the rounded write pulse, address-valid and select-valid times and the turnaround plus data setup (8 at defaults). `sram_oe_n_o` stays 1 for the whole write.
- R5: `sram_dq_oe_o` stays 0 for the first TURN_CYC write-pulse cycles (the larger of the two bus float times, 4 at defaults). It is 1 for the rest of the pulse and for exactly one cycle after `sram_we_n_o` rises, then 0.
- R6: Whenever `sram_dq_oe_o`=1, `sram_dq_o` equals the write data captured at acceptance.
- R7: Address and write data are registered at acceptance. Changes on `addr_i` and `wdata_i` during the cycle do not affect `sram_addr_o` or the written byte.
- R8: `ready_o` pulses for exactly one clock per accepted request. It comes RD_CYC+1 cycles after acceptance for a read, and PULSE_CYC+REC_CYC+1 cycles after for a write. REC_CYC is max(1, rounded write cycle time minus PULSE_CYC), which is 1 at defaults.
- R9: Requests that arrive from acceptance through the ready cycle start no memory cycle and produce no extra ready pulse.
- R10: In the ready cycle and in idle, `sram_sel_n_o`=1 and `sram_sel_o`=0.
- R11: Each cycle count is ceil(ns / CLK_NS), with a minimum of 1. At CLK_NS=8 and default timings this gives read strobe 9, write pulse 8, turnaround 4 and recovery 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, sampled in idle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 13 | Host address |
| wdata_i | input | 8 | Host write data |
| ready_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 8 | Captured read data |
| sram_addr_o | output | 13 | Memory address bus |
| sram_sel_n_o | output | 1 | Active-low chip select |
| sram_sel_o | output | 1 | Active-high chip select |
| sram_we_n_o | output | 1 | Write enable, active low |
| sram_oe_n_o | output | 1 | Output enable, active low |
| sram_dq_i | input | 8 | Data bus in |
| sram_dq_o | output | 8 | Data bus out |
| sram_dq_oe_o | output | 1 | Data bus drive enable |

## Verification
The main function is exercised with a sequence of writes and reads. The addresses include zero, all-ones and alternating bit patterns, so an address swap or a stuck bit reads back the wrong byte. An overwrite of a location, and a read of a location never written, tell a real store apart from a stale capture register.

While each cycle runs, the host address and data are inverted. A controller that passes the inputs straight through instead of registering them then shows up at once. Per-cycle counts of each strobe, the first drive-enable cycle and the ready position separate off-by-one errors in the ns-to-cycle rounding from errors in the turnaround window. A held request across a busy read, and a reset in the middle of a write, cover the ignore and abort paths.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [4:0] {
    ST_IDLE = 5'b00001,
    ST_RD   = 5'b00010,
    ST_WR   = 5'b00100,
    ST_REC  = 5'b01000,
    ST_DONE = 5'b10000
  } sram_st_e;

  // ceil(ns / clk_ns), never below one cycle
  function automatic int unsigned ns2cyc(int unsigned ns, int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == '0);

  AST_TIMER_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R11

endmodule

// File: rtl/sram_req_latch.sv
module sram_req_latch #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              cap_rd_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept_i) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (cap_rd_i) rdata_q <= rd_data_i;
  end

  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign rdata_o = rdata_q;

  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_i |=> $stable(addr_q)); // R7

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 13,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CLK_NS        = 8,
  parameter int unsigned RD_CYCLE_NS   = 70,
  parameter int unsigned ADDR_ACC_NS   = 70,
  parameter int unsigned OE_ACC_NS     = 35,
  parameter int unsigned OE_FLOAT_NS   = 30,
  parameter int unsigned WR_CYCLE_NS   = 70,
  parameter int unsigned WR_PULSE_NS   = 40,
  parameter int unsigned DATA_SETUP_NS = 30,
  parameter int unsigned ADDR_VALID_NS = 60,
  parameter int unsigned SEL_VALID_NS  = 60,
  parameter int unsigned WE_FLOAT_NS   = 30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_sel_n_o,
  output logic              sram_sel_o,
  output logic              sram_we_n_o,
  output logic              sram_oe_n_o,
  input  logic [DATA_W-1:0] sram_dq_i,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe_o
);

  localparam int unsigned RD_CYC    = max2(max2(ns2cyc(RD_CYCLE_NS, CLK_NS),
                                                ns2cyc(ADDR_ACC_NS, CLK_NS)),
                                           ns2cyc(OE_ACC_NS, CLK_NS));
  localparam int unsigned TURN_CYC  = max2(ns2cyc(WE_FLOAT_NS, CLK_NS),
                                           ns2cyc(OE_FLOAT_NS, CLK_NS));
  localparam int unsigned PULSE_CYC = max2(max2(ns2cyc(WR_PULSE_NS, CLK_NS),
                                                ns2cyc(ADDR_VALID_NS, CLK_NS)),
                                           max2(ns2cyc(SEL_VALID_NS, CLK_NS),
                                                TURN_CYC + ns2cyc(DATA_SETUP_NS, CLK_NS)));
  localparam int unsigned WC_CYC    = ns2cyc(WR_CYCLE_NS, CLK_NS);
  localparam int unsigned REC_CYC   = (WC_CYC > PULSE_CYC + 1) ? (WC_CYC - PULSE_CYC) : 1;
  localparam int unsigned CNT_MAX   = max2(RD_CYC, max2(PULSE_CYC, REC_CYC));
  localparam int unsigned CNT_W     = $clog2(CNT_MAX + 1);

  localparam logic [CNT_W-1:0] RD_LD    = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LD   = CNT_W'(REC_CYC - 1);
  localparam logic [CNT_W-1:0] DRV_TOP  = CNT_W'(PULSE_CYC - 1 - TURN_CYC);

  sram_st_e         state_q, state_d;
  logic             accept, cap_rd, load;
  logic [CNT_W-1:0] load_val, cnt;
  logic             last;
  logic [DATA_W-1:0] wdata_q;

  always_comb begin
    state_d  = state_q;
    accept   = 1'b0;
    cap_rd   = 1'b0;
    load     = 1'b0;
    load_val = '0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        accept   = 1'b1;
        load     = 1'b1;
        load_val = we_i ? PULSE_LD : RD_LD;
        state_d  = we_i ? ST_WR : ST_RD;
      end
      ST_RD: if (last) begin
        cap_rd  = 1'b1;
        state_d = ST_DONE;
      end
      ST_WR: if (last) begin
        load     = 1'b1;
        load_val = REC_LD;
        state_d  = ST_REC;
      end
      ST_REC:  if (last) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .cnt_o      (cnt),
    .last_o     (last)
  );

  sram_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .cap_rd_i  (cap_rd),
    .rd_data_i (sram_dq_i),
    .addr_o    (sram_addr_o),
    .wdata_o   (wdata_q),
    .rdata_o   (rdata_o)
  );

  // strobes decode from one-hot state flops only
  logic sel_act;
  assign sel_act      = (state_q == ST_RD) || (state_q == ST_WR) || (state_q == ST_REC);
  assign sram_sel_n_o = !sel_act;
  assign sram_sel_o   = sel_act;
  assign sram_we_n_o  = (state_q != ST_WR);
  assign sram_oe_n_o  = (state_q != ST_RD);
  assign ready_o      = (state_q == ST_DONE);
  assign sram_dq_o    = wdata_q;
  // drive after bus float time, release one cycle after write strobe ends
  assign sram_dq_oe_o = ((state_q == ST_WR) && (cnt <= DRV_TOP)) ||
                        ((state_q == ST_REC) && (cnt == REC_LD));

  AST_READY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o); // R8
  AST_READY_DESEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (sram_sel_n_o && !sram_sel_o)); // R10
  AST_WE_OE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_n_o |-> sram_oe_n_o); // R4
  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_dq_oe_o |-> sram_oe_n_o); // R5
  AST_DRIVE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_n_o) |-> sram_dq_oe_o); // R5
  AST_DRIVE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_n_o) |=> !sram_dq_oe_o); // R5
  AST_DRIVE_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_dq_oe_o && $past(sram_dq_oe_o)) |-> $stable(sram_dq_o)); // R6
  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_sel_n_o && $past(!sram_sel_n_o)) |-> $stable(sram_addr_o)); // R7
  AST_BUSY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_act && !last) |=> sel_act); // R9

endmodule

// File: tb/sram_async_ctrl_tb.sv
module sram_async_ctrl_tb;

  localparam int CLK_NS = 8;
  localparam int EXP_RD    = (70 + CLK_NS - 1) / CLK_NS;                       // 9
  localparam int EXP_TURN  = (30 + CLK_NS - 1) / CLK_NS;                       // 4
  localparam int EXP_PULSE = ((60 + CLK_NS - 1) / CLK_NS > EXP_TURN + (30 + CLK_NS - 1) / CLK_NS)
                             ? (60 + CLK_NS - 1) / CLK_NS
                             : EXP_TURN + (30 + CLK_NS - 1) / CLK_NS;          // 8
  localparam int EXP_REC   = 1;

  typedef struct packed {
    logic        we;
    logic [12:0] addr;
    logic [7:0]  wd;
    logic [7:0]  exp;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 13'h0000, 8'h3C, 8'h00},
    '{1'b1, 13'h1FFF, 8'hC3, 8'h00},
    '{1'b1, 13'h0AAA, 8'h55, 8'h00},
    '{1'b0, 13'h0000, 8'h00, 8'h3C},
    '{1'b0, 13'h1FFF, 8'h00, 8'hC3},
    '{1'b0, 13'h0AAA, 8'h00, 8'h55},
    '{1'b1, 13'h0AAA, 8'hFF, 8'h00},
    '{1'b0, 13'h0AAA, 8'h00, 8'hFF},
    '{1'b0, 13'h1555, 8'h00, 8'h00}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 1'b0, we_i = 1'b0;
  logic [12:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic ready_o, sram_sel_n_o, sram_sel_o, sram_we_n_o, sram_oe_n_o, sram_dq_oe_o;
  logic [7:0]  rdata_o, sram_dq_i, sram_dq_o;
  logic [12:0] sram_addr_o;

  always #4 clk = ~clk;

  sram_async_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .ready_o(ready_o), .rdata_o(rdata_o),
    .sram_addr_o(sram_addr_o), .sram_sel_n_o(sram_sel_n_o), .sram_sel_o(sram_sel_o),
    .sram_we_n_o(sram_we_n_o), .sram_oe_n_o(sram_oe_n_o), .sram_dq_i(sram_dq_i),
    .sram_dq_o(sram_dq_o), .sram_dq_oe_o(sram_dq_oe_o)
  );

  // memory model
  logic [7:0] mem [8192];
  wire sel_on = !sram_sel_n_o && sram_sel_o;
  assign sram_dq_i = (sel_on && !sram_oe_n_o && sram_we_n_o) ? mem[sram_addr_o] : 8'hA5;
  always @(negedge clk)
    if (sel_on && !sram_we_n_o && sram_dq_oe_o) mem[sram_addr_o] <= sram_dq_o;

  int total = 0, bad = 0;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  int oe_cnt, we_cnt, dq_cnt, dq_first, rdy_at, rdy_cnt, addr_bad, dq_bad, desel_bad, oe_in_wr;
  logic [7:0] rd_val;

  task automatic run_op(input logic w, input logic [12:0] a, input logic [7:0] d, input bit hold_req);
    @(negedge clk);
    req_i = 1'b1; we_i = w; addr_i = a; wdata_i = d;
    @(negedge clk);
    if (!hold_req) req_i = 1'b0; else we_i = 1'b1;
    addr_i = ~a; wdata_i = ~d;
    oe_cnt = 0; we_cnt = 0; dq_cnt = 0; dq_first = 0; rdy_at = 0; rdy_cnt = 0;
    addr_bad = 0; dq_bad = 0; desel_bad = 0; oe_in_wr = 0; rd_val = '0;
    for (int k = 1; k <= 15; k++) begin
      if (k == 10) req_i = 1'b0;
      if (sel_on && !sram_oe_n_o && sram_we_n_o) oe_cnt++;
      if (sel_on && !sram_we_n_o) we_cnt++;
      if (w && !sram_oe_n_o) oe_in_wr++;
      if (sram_dq_oe_o) begin
        dq_cnt++;
        if (dq_first == 0) dq_first = k;
        if (sram_dq_o != d) dq_bad++;
      end
      if (sel_on && sram_addr_o != a) addr_bad++;
      if (ready_o) begin
        rdy_cnt++;
        if (rdy_at == 0) rdy_at = k;
        rd_val = rdata_o;
      end
      if (k >= 10 && !(sram_sel_n_o && !sram_sel_o)) desel_bad++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8192; i++) mem[i] = 8'h00;
    #3;
    // R1: during reset
    chk("R1 sel_n in reset", sram_sel_n_o, 1);
    chk("R1 sel in reset", sram_sel_o, 0);
    chk("R1 we_n/oe_n in reset", {sram_we_n_o, sram_oe_n_o}, 2'b11);
    chk("R1 dq_oe/ready in reset", {sram_dq_oe_o, ready_o}, 2'b00);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle strobes", {sram_sel_n_o, sram_sel_o, sram_we_n_o, sram_oe_n_o, sram_dq_oe_o, ready_o}, 6'b101100);

    for (int v = 0; v < NV; v++) begin
      run_op(VEC[v].we, VEC[v].addr, VEC[v].wd, 1'b0);
      chk("R8 ready count", rdy_cnt, 1);
      chk("R7 address held", addr_bad, 0);
      chk("R10 deselect after cycle", desel_bad, 0);
      if (VEC[v].we) begin
        chk("R4/R11 write pulse cycles", we_cnt, EXP_PULSE);
        chk("R4 oe high in write", oe_in_wr, 0);
        chk("R5 first drive cycle", dq_first, EXP_TURN + 1);
        chk("R5 drive cycles", dq_cnt, EXP_PULSE - EXP_TURN + 1);
        chk("R6/R7 drive data", dq_bad, 0);
        chk("R8 write ready pos", rdy_at, EXP_PULSE + EXP_REC + 1);
      end else begin
        chk("R2/R11 read strobe cycles", oe_cnt, EXP_RD);
        chk("R2 no drive on read", dq_cnt, 0);
        chk("R8 read ready pos", rdy_at, EXP_RD + 1);
        chk("R3 read data", rd_val, VEC[v].exp);
      end
    end
    chk("R3 rdata held", rdata_o, 8'h00);

    // R9: request held high (and flagged write) across a busy read
    run_op(1'b0, 13'h0AAA, 8'h00, 1'b1);
    chk("R9 single ready", rdy_cnt, 1);
    chk("R9 no write started", we_cnt, 0);
    chk("R9 no new cycle", desel_bad, 0);
    chk("R9 read data intact", rd_val, 8'hFF);

    // R1: reset in the middle of a write
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b1; addr_i = 13'h0123; wdata_i = 8'h77;
    @(negedge clk); req_i = 1'b0;
    repeat (5) @(negedge clk);
    chk("R5 drive on mid write", sram_dq_oe_o, 1);
    rst_ni = 1'b0;
    #1;
    chk("R1 async abort", {sram_sel_n_o, sram_sel_o, sram_we_n_o, sram_oe_n_o, sram_dq_oe_o, ready_o}, 6'b101100);
    @(negedge clk); rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle after abort", {sram_sel_n_o, ready_o}, 2'b10);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule